// File: doc/BRIEF.md
# Sleep-Triggered ADC Conversion Controller

This controller sits between a processor's sleep logic and an ADC conversion engine. It starts one conversion on its own when the processor halts in a quiet sleep mode. The quiet modes are Idle and the dedicated low-noise mode. Starting the conversion after the halt keeps switching noise from the core out of the sample. When the converter reports completion, the controller raises a sticky completion interrupt. It also sends a one-cycle wake request, but only when nothing else has already woken the processor.

The controller also tracks how reliable each result is. A change of the reference source, or a fresh enable of the converter, makes the next delivered result suspect. A fresh enable also makes the next start an extended (longer) conversion. The converter, the reference circuits and the processor core are outside the block and talk to it only through strobes and levels.

Top module: `slpadc_ctrl`

## Requirements
- R1: A conversion starts only when the sleep mode code is Idle (0) or low-noise (1). Every other code (2 to 7) starts nothing.
- R2: A start also needs all of the following on the same cycle: `en_i` high, `single_i` high, `irq_en_i` high, and no conversion in progress. If any one is missing, the halt starts nothing.
- R3: `conv_start_o` pulses for exactly one cycle, in the cycle after the first clock edge that samples `cpu_halt_i` high. Holding `cpu_halt_i` high never starts a second conversion; a new start needs `cpu_halt_i` to go low and then high again.
- R4: `busy_o` rises together with `conv_start_o`. It falls on the edge that samples `conv_done_i` while busy, or as soon as `en_i` is low. While busy, a new halt is ignored, whatever its sleep mode.
- R5: `conv_done_i` sampled while busy sets `irq_o` on the next edge. `irq_o` stays high until `irq_clr_i` is sampled high on a cycle without such a completion. A completion on the same cycle as the clear leaves `irq_o` high. A `conv_done_i` seen while not busy has no effect.
- R6: `wake_o` is a one-cycle pulse that comes with a completion. It is sent only if `other_wake_i` was not sampled high at any point between the start and the completion. If another source woke the processor first, the completion still sets `irq_o` but sends no wake.
- R7: The first start after each low-to-high change of `en_i` has `conv_ext_o` high together with `conv_start_o`. Later starts have `conv_ext_o` low.
- R8: `suspect_o` is updated only on a completion, and then holds. It goes high for a result if the conversion was started after a change of `ref_sel_i` or a rise of `en_i` that no earlier start has consumed, or if such an event happens during the conversion. Otherwise it goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Converter enable |
| single_i | input | 1 | Single-conversion mode selected |
| irq_en_i | input | 1 | Completion interrupt enabled |
| sleep_mode_i | input | 3 | Sleep mode code (0 Idle, 1 low-noise, others deeper modes) |
| cpu_halt_i | input | 1 | High while the processor is halted |
| conv_done_i | input | 1 | Completion strobe from the converter |
| other_wake_i | input | 1 | Another wake source is active |
| irq_clr_i | input | 1 | Clears the completion interrupt |
| ref_sel_i | input | 2 | Reference source select (supply, 1.1 V, 2.56 V, external pin) |
| conv_start_o | output | 1 | One-cycle conversion start |
| conv_ext_o | output | 1 | The current start is an extended conversion |
| busy_o | output | 1 | Conversion in progress |
| irq_o | output | 1 | Completion interrupt request |
| wake_o | output | 1 | One-cycle processor wake request |
| suspect_o | output | 1 | The last delivered result may be inaccurate |

## Verification
Some properties are checked on every cycle by assertions: a start always follows a qualifying mode and a full set of enables, a start is never longer than one cycle, busy follows a start, and a completion sets the interrupt. The suspect flag is also checked to change only at a completion. Other behaviour needs ordered scenarios: the early wake by another source, the held halt that must not relaunch, the clear that lands on a completion, and the chain of reference change, re-enable and the clean result that follows. Only the bench's scenarios show these. The bench sweeps every sleep code against every combination of the three enables.

// File: rtl/slpadc_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the sleep-triggered ADC controller.
// Assumes the sleep controller presents its mode as a 3-bit code.
package slpadc_pkg;
    localparam int SLP_W = 3;

    typedef enum logic [SLP_W-1:0] {
        SLP_IDLE    = 3'd0,
        SLP_QUIET   = 3'd1,
        SLP_PWRDN   = 3'd2,
        SLP_PWRSAVE = 3'd3,
        SLP_STBY    = 3'd6,
        SLP_XSTBY   = 3'd7
    } slp_mode_e;

    // True for the sleep modes in which a halt launches a conversion.
    function automatic logic mode_is_quiet(input logic [SLP_W-1:0] m);
        return (m == SLP_IDLE) || (m == SLP_QUIET);
    endfunction
endpackage

// File: rtl/slpadc_launch.sv
`timescale 1ns/1ps
// Launch sequencer: detects a fresh processor halt, checks the launch
// conditions and issues a one-cycle start, with the extended flag for
// the first start after an enable rise. Owns the busy state.
// Assumes cpu_halt_i is a level that stays high while halted.
module slpadc_launch
    import slpadc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             single_i,
    input  logic             irq_en_i,
    input  logic [SLP_W-1:0] sleep_mode_i,
    input  logic             cpu_halt_i,
    input  logic             conv_done_i,
    output logic             start_o,
    output logic             ext_o,
    output logic             busy_o,
    output logic             launch_o,
    output logic             done_ok_o,
    output logic             en_rise_o
);
    logic halt_q, en_q, ext_pend, start_q, ext_q, busy_q;

    logic halt_rise, launch;
    assign halt_rise = cpu_halt_i & ~halt_q;
    assign en_rise_o = en_i & ~en_q;
    assign launch    = halt_rise & mode_is_quiet(sleep_mode_i) & en_i
                     & single_i & irq_en_i & ~busy_q;
    assign done_ok_o = conv_done_i & busy_q;
    assign launch_o  = launch;

    // Edge-detect history of halt and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            halt_q <= cpu_halt_i;
            en_q   <= en_i;
        end
    end

    // Remember that the next start must be extended.
    always_ff @(posedge clk) begin
        if (!rst_n)          ext_pend <= 1'b0;
        else if (launch)     ext_pend <= 1'b0;
        else if (en_rise_o)  ext_pend <= 1'b1;
    end

    // One-cycle start pulse and its extended qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            ext_q   <= 1'b0;
        end else begin
            start_q <= launch;
            ext_q   <= launch & (ext_pend | en_rise_o);
        end
    end

    // Busy from start until completion or disable.
    always_ff @(posedge clk) begin
        if (!rst_n)          busy_q <= 1'b0;
        else if (!en_i)      busy_q <= 1'b0;
        else if (launch)     busy_q <= 1'b1;
        else if (done_ok_o)  busy_q <= 1'b0;
    end

    assign start_o = start_q;
    assign ext_o   = ext_q;
    assign busy_o  = busy_q;

    a_r1_quiet_mode: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> $past(mode_is_quiet(sleep_mode_i)));
    a_r2_all_enables: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> $past(en_i && single_i && irq_en_i && !busy_q));
    a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);
    a_r4_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> busy_q);
    a_r7_ext_only_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        ext_q |-> start_q);
endmodule

// File: rtl/slpadc_irq.sv
`timescale 1ns/1ps
// Completion signalling: sticky interrupt request and a wake pulse that
// is withheld when another source woke the processor during the run.
// Assumes done_ok_i is already qualified by the busy state.
module slpadc_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    input  logic busy_i,
    input  logic done_ok_i,
    input  logic other_wake_i,
    input  logic irq_clr_i,
    output logic irq_o,
    output logic wake_o
);
    logic irq_q, wake_q, woke_q;

    // Sticky interrupt: completion wins over a clear on the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq_q <= 1'b0;
        else if (done_ok_i)  irq_q <= 1'b1;
        else if (irq_clr_i)  irq_q <= 1'b0;
    end

    // Record an earlier wake by another source during the current run.
    always_ff @(posedge clk) begin
        if (!rst_n)                      woke_q <= 1'b0;
        else if (launch_i)               woke_q <= 1'b0;
        else if (busy_i && other_wake_i) woke_q <= 1'b1;
    end

    // Wake pulse on a completion nobody else has answered.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= done_ok_i & ~woke_q & ~other_wake_i;
    end

    assign irq_o  = irq_q;
    assign wake_o = wake_q;

    a_r5_irq_sets: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok_i |=> irq_q);
    a_r5_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_i && !done_ok_i) |=> !irq_q);
    a_r6_no_late_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (woke_q && done_ok_i) |=> !wake_q);
    a_r6_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |=> !wake_q);
endmodule

// File: rtl/slpadc_qual.sv
`timescale 1ns/1ps
// Result quality tracker: marks the result that follows a reference
// change or an enable rise as suspect, and clears after one such result.
// Assumes launch_i and done_ok_i come from the launch sequencer.
module slpadc_qual #(
    parameter int REF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REF_W-1:0] ref_sel_i,
    input  logic             en_rise_i,
    input  logic             launch_i,
    input  logic             busy_i,
    input  logic             done_ok_i,
    output logic             suspect_o
);
    logic [REF_W-1:0] ref_q;
    logic dirty_q, tag_q, suspect_q;
    logic mark;
    assign mark = (ref_sel_i != ref_q) | en_rise_i;

    // Track the last reference selection.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= '0;
        else        ref_q <= ref_sel_i;
    end

    // Unconsumed disturbance waiting for the next start.
    always_ff @(posedge clk) begin
        if (!rst_n)        dirty_q <= 1'b0;
        else if (launch_i) dirty_q <= mark;
        else if (mark)     dirty_q <= 1'b1;
    end

    // Quality tag of the conversion in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)              tag_q <= 1'b0;
        else if (launch_i)       tag_q <= dirty_q | mark;
        else if (mark && busy_i) tag_q <= 1'b1;
    end

    // Deliver the tag with each result.
    always_ff @(posedge clk) begin
        if (!rst_n)         suspect_q <= 1'b0;
        else if (done_ok_i) suspect_q <= tag_q | mark;
    end

    assign suspect_o = suspect_q;

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_ok_i |=> $stable(suspect_q));
    a_r8_tagged: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok_i && tag_q) |=> suspect_q);
endmodule

// File: rtl/slpadc_ctrl.sv
`timescale 1ns/1ps
// Top of the sleep-triggered ADC conversion controller. Wires the launch
// sequencer, completion signalling and quality tracker together.
// Assumes all inputs are synchronous to clk.
module slpadc_ctrl
    import slpadc_pkg::*;
#(
    parameter int REF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             single_i,
    input  logic             irq_en_i,
    input  logic [SLP_W-1:0] sleep_mode_i,
    input  logic             cpu_halt_i,
    input  logic             conv_done_i,
    input  logic             other_wake_i,
    input  logic             irq_clr_i,
    input  logic [REF_W-1:0] ref_sel_i,
    output logic             conv_start_o,
    output logic             conv_ext_o,
    output logic             busy_o,
    output logic             irq_o,
    output logic             wake_o,
    output logic             suspect_o
);
    logic launch, done_ok, en_rise;

    slpadc_launch u_launch (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .single_i(single_i),
        .irq_en_i(irq_en_i), .sleep_mode_i(sleep_mode_i),
        .cpu_halt_i(cpu_halt_i), .conv_done_i(conv_done_i),
        .start_o(conv_start_o), .ext_o(conv_ext_o), .busy_o(busy_o),
        .launch_o(launch), .done_ok_o(done_ok), .en_rise_o(en_rise)
    );

    slpadc_irq u_irq (
        .clk(clk), .rst_n(rst_n), .launch_i(launch), .busy_i(busy_o),
        .done_ok_i(done_ok), .other_wake_i(other_wake_i),
        .irq_clr_i(irq_clr_i), .irq_o(irq_o), .wake_o(wake_o)
    );

    slpadc_qual #(.REF_W(REF_W)) u_qual (
        .clk(clk), .rst_n(rst_n), .ref_sel_i(ref_sel_i), .en_rise_i(en_rise),
        .launch_i(launch), .busy_i(busy_o), .done_ok_i(done_ok),
        .suspect_o(suspect_o)
    );
endmodule

// File: tb/tb_slpadc_ctrl.sv
`timescale 1ns/1ps
module tb_slpadc_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 1'b0, single_i = 1'b0, irq_en_i = 1'b0;
    logic [2:0] sleep_mode_i = 3'd0;
    logic cpu_halt_i = 1'b0, conv_done_i = 1'b0, other_wake_i = 1'b0, irq_clr_i = 1'b0;
    logic [1:0] ref_sel_i = 2'd0;
    logic conv_start_o, conv_ext_o, busy_o, irq_o, wake_o, suspect_o;
    int checks = 0, fails = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    slpadc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .single_i(single_i),
        .irq_en_i(irq_en_i), .sleep_mode_i(sleep_mode_i), .cpu_halt_i(cpu_halt_i),
        .conv_done_i(conv_done_i), .other_wake_i(other_wake_i), .irq_clr_i(irq_clr_i),
        .ref_sel_i(ref_sel_i), .conv_start_o(conv_start_o), .conv_ext_o(conv_ext_o),
        .busy_o(busy_o), .irq_o(irq_o), .wake_o(wake_o), .suspect_o(suspect_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Fresh halt edge; after return the start pulse is visible.
    task automatic halt_edge();
        cpu_halt_i = 1'b0; tick();
        cpu_halt_i = 1'b1; tick();
    endtask

    task automatic complete();
        conv_done_i = 1'b1; tick();
        conv_done_i = 1'b0;
    endtask

    task automatic clear_irq();
        irq_clr_i = 1'b1; tick();
        irq_clr_i = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        chk("R4 reset busy", busy_o, 1'b0);
        chk("R5 reset irq", irq_o, 1'b0);
        chk("R8 reset suspect", suspect_o, 1'b0);

        // R1 R2: sweep every sleep code against all enable combinations
        for (int c = 0; c < 64; c++) begin
            logic exp;
            sleep_mode_i = c[2:0]; en_i = c[3]; single_i = c[4]; irq_en_i = c[5];
            cpu_halt_i = 1'b0; tick(2);
            cpu_halt_i = 1'b1; tick();
            exp = (c[2:0] < 3'd2) && c[3] && c[4] && c[5];
            chk("R1 R2 start", conv_start_o, exp);
            chk("R4 busy", busy_o, exp);
            tick();
            chk("R3 held halt", conv_start_o, 1'b0);
            cpu_halt_i = 1'b0;
            if (exp) begin
                complete(); tick();
                chk("R5 irq set", irq_o, 1'b1);
                clear_irq();
                chk("R5 irq clear", irq_o, 1'b0);
            end
        end

        // R7 R8: toggle enable, first conversion extended and suspect
        en_i = 1'b0; single_i = 1'b1; irq_en_i = 1'b1; sleep_mode_i = 3'd1;
        tick(2); en_i = 1'b1; tick(2);
        halt_edge();
        chk("R7 first ext", conv_ext_o, 1'b1);
        chk("R3 start", conv_start_o, 1'b1);
        tick();
        chk("R8 suspect holds before done", suspect_o, 1'b0);
        complete();
        chk("R6 wake", wake_o, 1'b1);
        chk("R5 irq", irq_o, 1'b1);
        chk("R8 suspect after enable", suspect_o, 1'b1);
        tick();
        chk("R6 wake pulse", wake_o, 1'b0);
        chk("R3 held halt after done", conv_start_o, 1'b0);
        tick(3);
        chk("R3 no relaunch", busy_o, 1'b0);
        clear_irq();

        // R7 R8: second conversion clean
        halt_edge();
        chk("R7 second not ext", conv_ext_o, 1'b0);
        chk("R3 restart on fresh edge", conv_start_o, 1'b1);
        // R4: new halt while busy, deep mode, ignored and not aborted
        sleep_mode_i = 3'd2;
        halt_edge();
        chk("R4 halt while busy", conv_start_o, 1'b0);
        chk("R4 still busy", busy_o, 1'b1);
        sleep_mode_i = 3'd0;
        halt_edge();
        chk("R4 idle halt while busy", conv_start_o, 1'b0);
        complete();
        chk("R8 clean result", suspect_o, 1'b0);
        chk("R4 busy cleared", busy_o, 1'b0);
        // R5: done + clear same cycle keeps irq
        halt_edge();
        conv_done_i = 1'b1; irq_clr_i = 1'b1; tick();
        conv_done_i = 1'b0; irq_clr_i = 1'b0;
        chk("R5 done beats clear", irq_o, 1'b1);
        clear_irq();
        // R5: stray done while idle ignored
        complete();
        chk("R5 stray done", irq_o, 1'b0);
        chk("R6 stray done wake", wake_o, 1'b0);

        // R6: other wake during conversion
        halt_edge();
        other_wake_i = 1'b1; tick(); other_wake_i = 1'b0; tick();
        complete();
        chk("R6 irq after early wake", irq_o, 1'b1);
        chk("R6 no wake after early wake", wake_o, 1'b0);
        clear_irq();

        // R8: reference change makes next result suspect, then clean
        ref_sel_i = 2'd2; tick(2);
        halt_edge(); complete();
        chk("R8 suspect after ref change", suspect_o, 1'b1);
        halt_edge(); complete();
        chk("R8 clears after one result", suspect_o, 1'b0);
        // R8: change during a run
        halt_edge(); ref_sel_i = 2'd3; tick(); complete();
        chk("R8 change during run", suspect_o, 1'b1);
        halt_edge(); complete();
        chk("R8 run after in-flight change", suspect_o, 1'b1);
        clear_irq();

        // R4: disable while busy clears busy; R7 next start extended
        halt_edge();
        en_i = 1'b0; tick();
        chk("R4 disable clears busy", busy_o, 1'b0);
        en_i = 1'b1; tick(2);
        halt_edge();
        chk("R7 ext after re-enable", conv_ext_o, 1'b1);
        complete();
        chk("R8 suspect after re-enable", suspect_o, 1'b1);

        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done_flag) begin
            done_flag = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule